// File: doc/BRIEF.md
# Block-Checksum DMA Engine

This engine walks a window of byte-addressed buffer RAM and folds its contents into the 16-bit Internet checksum. The host loads three values through a small register port: where the window starts, how many bytes it holds, and an optional 16-bit seed. It then writes the control register with the go bit set. The engine issues one RAM read per clock. It pairs consecutive bytes into 16-bit words, with the first byte of each pair as the high byte. It adds the words with end-around carry and stores the ones' complement of the total in a result register. When it finishes, the hardware drops the go bit, and a done pulse and an interrupt pulse mark the completion.

The control register also has a copy selector and a seed selector. The engine performs checksums only, so a start request that asks for a copy is refused. Because the seed selector exists, a checksum that was computed in parts can be continued in a later pass. A parameter can also turn on a variant that reports an all-zero result as FFFFh.

Top module: `cks_dma_engine`

## Requirements
- R1: After reset, every readable register (offset 0 control, 1 start address, 2 length, 3 seed, 4 result) reads 0000h, done_o and irq_o are low, and mem_rd_en is low.
- R2: A write to offset 0 with bit 0 (go) set and bit 1 (copy) clear, made while idle, starts an operation. Bit 0 of the control register reads 1 from the next cycle on. It clears at the clock edge that lies L+1 edges after the start write, where L is the length. done_o and irq_o are both high for exactly the one cycle after that edge.
- R3: Words are big-endian: the byte at an even offset from the start address is the high byte. When the length is odd, the last byte is padded with a zero low byte.
- R4: The result register (offset 4) holds the ones' complement of the end-around-carry sum of all words and the seed.
- R5: Control bit 2 selects the seed. When it is 0 the seed is 0000h, and the seed register has no effect. When it is 1 the value at offset 3 is used.
- R6: A length of 0 completes at the next edge and returns the complement of the selected seed.
- R7: Read addresses advance by one per read and wrap from BUF_BYTES-1 to 0.
- R8: A control write with bit 1 (copy) set does not start an operation. No reads are issued, bit 0 stays 0, and the result is unchanged.
- R9: While an operation runs, register writes are ignored. The start address, length and seed keep their values.
- R10: With MAP_ZERO=1, a result of 0000h is reported as FFFFh.
- R11: An operation of length L asserts mem_rd_en on exactly L consecutive cycles. mem_rd_en is low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational from reg_addr) |
| mem_rd_en | output | 1 | RAM read request |
| mem_addr | output | ADDR_W | RAM byte address |
| mem_rd_data | input | 8 | RAM data, valid one cycle after the request |
| done_o | output | 1 | One-cycle completion flag |
| irq_o | output | 1 | One-cycle completion interrupt request |

## Verification
The bench builds the engine with ADDR_W=6, LEN_W=8, BUF_BYTES=48 and MAP_ZERO=1. The 48-byte buffer is not a power of two, so a window that crosses its end exercises the wrap to address 0 and not a natural roll-over of the address counter. The 8-bit length allows a window that covers nearly the whole buffer and produces many end-around carries within a few hundred cycles. MAP_ZERO=1 makes the all-ones sum case, which maps 0000h to FFFFh, reachable and visible.

// File: rtl/cks_pkg.sv
package cks_pkg;

   // Register offsets seen on the register port
   typedef enum logic [2:0] {
      RS_CTRL = 3'd0,
      RS_BASE = 3'd1,
      RS_LEN  = 3'd2,
      RS_SEED = 3'd3,
      RS_SUM  = 3'd4
   } reg_sel_e;

   // Control register bit positions
   localparam int unsigned CB_GO   = 0;
   localparam int unsigned CB_COPY = 1;
   localparam int unsigned CB_SEED = 2;

   localparam int unsigned WORD_W = 16;

   // Ones'-complement addition with end-around carry
   function automatic logic [WORD_W-1:0] oc_add16(input logic [WORD_W-1:0] a,
                                                  input logic [WORD_W-1:0] b);
      logic [WORD_W:0] s;
      s = {1'b0, a} + {1'b0, b};
      return s[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, s[WORD_W]};
   endfunction

endpackage

// File: rtl/cks_regs.sv
module cks_regs
   import cks_pkg::*;
#(
   parameter int unsigned ADDR_W = 15,
   parameter int unsigned LEN_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [2:0]          addr,
   input  logic [WORD_W-1:0]   wdata,
   input  logic                finish,
   input  logic [WORD_W-1:0]   result_in,
   output logic                busy,
   output logic                launch,
   output logic [ADDR_W-1:0]   base,
   output logic [LEN_W-1:0]    len,
   output logic [WORD_W-1:0]   launch_seed,
   output logic [WORD_W-1:0]   rdata
);

   logic                busy_q;
   logic                copy_q;
   logic                seedsel_q;
   logic [ADDR_W-1:0]   base_q;
   logic [LEN_W-1:0]    len_q;
   logic [WORD_W-1:0]   seed_q;
   logic [WORD_W-1:0]   sum_q;
   logic                idle_wr;
   reg_sel_e            sel;

   assign sel     = reg_sel_e'(addr);
   assign idle_wr = we && !busy_q;
   assign launch  = idle_wr && (sel == RS_CTRL) && wdata[CB_GO] && !wdata[CB_COPY];
   // seed selector written in the same cycle as go takes effect at once
   assign launch_seed = wdata[CB_SEED] ? seed_q : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         copy_q    <= 1'b0;
         seedsel_q <= 1'b0;
         base_q    <= '0;
         len_q     <= '0;
         seed_q    <= '0;
         sum_q     <= '0;
      end else begin
         if (idle_wr) begin
            case (sel)
               RS_CTRL: begin
                  copy_q    <= wdata[CB_COPY];
                  seedsel_q <= wdata[CB_SEED];
               end
               RS_BASE: base_q <= wdata[ADDR_W-1:0];
               RS_LEN:  len_q  <= wdata[LEN_W-1:0];
               RS_SEED: seed_q <= wdata;
               default: ;
            endcase
         end
         if (launch) begin
            busy_q <= 1'b1;
         end else if (finish) begin
            busy_q <= 1'b0;
         end
         if (finish) begin
            sum_q <= result_in;
         end
      end
   end

   always_comb begin
      case (sel)
         RS_CTRL: rdata = WORD_W'({seedsel_q, copy_q, busy_q});
         RS_BASE: rdata = WORD_W'(base_q);
         RS_LEN:  rdata = WORD_W'(len_q);
         RS_SEED: rdata = seed_q;
         RS_SUM:  rdata = sum_q;
         default: rdata = '0;
      endcase
   end

   assign busy = busy_q;
   assign base = base_q;
   assign len  = len_q;

endmodule

// File: rtl/cks_fetch.sv
module cks_fetch #(
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned BUF_BYTES = 24576
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic [ADDR_W-1:0]  base,
   input  logic [LEN_W-1:0]   len,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic               byte_vld,
   output logic               byte_even,
   output logic               byte_last,
   output logic               empty_fin
);

   localparam logic [ADDR_W-1:0] WRAP_AT = ADDR_W'(BUF_BYTES - 1);
   localparam logic [LEN_W-1:0]  ONE_LEFT = LEN_W'(1);

   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  rem_q;
   logic              odd_q;
   logic              empty_q;
   logic              vld_q;
   logic              even_q;
   logic              last_q;
   logic              issuing;

   assign issuing = (rem_q != '0);

   // issue side: one byte address per cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         rem_q   <= '0;
         odd_q   <= 1'b0;
         empty_q <= 1'b0;
      end else if (launch) begin
         addr_q  <= base;
         rem_q   <= len;
         odd_q   <= 1'b0;
         empty_q <= (len == '0);
      end else begin
         empty_q <= 1'b0;
         if (issuing) begin
            addr_q <= (addr_q == WRAP_AT) ? '0 : addr_q + 1'b1;
            rem_q  <= rem_q - 1'b1;
            odd_q  <= ~odd_q;
         end
      end
   end

   // return side: tags aligned with the one-cycle RAM latency
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         even_q <= 1'b0;
         last_q <= 1'b0;
      end else begin
         vld_q  <= issuing;
         even_q <= ~odd_q;
         last_q <= (rem_q == ONE_LEFT);
      end
   end

   assign mem_rd_en = issuing;
   assign mem_addr  = addr_q;
   assign byte_vld  = vld_q;
   assign byte_even = even_q;
   assign byte_last = last_q;
   assign empty_fin = empty_q;

endmodule

// File: rtl/cks_accum.sv
module cks_accum
   import cks_pkg::*;
#(
   parameter int unsigned MAP_ZERO = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               launch,
   input  logic [WORD_W-1:0]  launch_seed,
   input  logic               byte_vld,
   input  logic               byte_even,
   input  logic               byte_last,
   input  logic [7:0]         byte_data,
   input  logic               empty_fin,
   output logic               finish,
   output logic [WORD_W-1:0]  result
);

   logic [WORD_W-1:0] acc_q;
   logic [7:0]        hi_q;
   logic [WORD_W-1:0] word;
   logic              add_word;
   logic [WORD_W-1:0] sum_next;
   logic [WORD_W-1:0] final_sum;
   logic [WORD_W-1:0] raw;

   assign word      = byte_even ? {byte_data, 8'h00} : {hi_q, byte_data};
   assign add_word  = byte_vld && (!byte_even || byte_last);
   assign sum_next  = oc_add16(acc_q, word);
   assign finish    = empty_fin || (byte_vld && byte_last);
   assign final_sum = empty_fin ? acc_q : sum_next;
   assign raw       = ~final_sum;

   generate
      if (MAP_ZERO != 0) begin : g_map_zero
         assign result = (raw == '0) ? '1 : raw;
      end else begin : g_plain
         assign result = raw;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         hi_q  <= '0;
      end else begin
         if (launch) begin
            acc_q <= launch_seed;
         end else if (add_word) begin
            acc_q <= sum_next;
         end
         if (byte_vld && byte_even) begin
            hi_q <= byte_data;
         end
      end
   end

endmodule

// File: rtl/cks_dma_engine.sv
module cks_dma_engine
   import cks_pkg::*;
#(
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned BUF_BYTES = 24576,
   parameter int unsigned MAP_ZERO  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [7:0]        mem_rd_data,
   output logic              done_o,
   output logic              irq_o
);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= WORD_W)
         else $fatal(1, "ADDR_W must lie in 1..16");
      assert (LEN_W >= 1 && LEN_W <= WORD_W)
         else $fatal(1, "LEN_W must lie in 1..16");
      assert (BUF_BYTES >= 2 && BUF_BYTES <= (1 << ADDR_W))
         else $fatal(1, "BUF_BYTES must fit the address width");
      assert (MAP_ZERO <= 1)
         else $fatal(1, "MAP_ZERO must be 0 or 1");
   end

   logic              busy;
   logic              launch;
   logic [ADDR_W-1:0] base;
   logic [LEN_W-1:0]  len;
   logic [15:0]       launch_seed;
   logic              finish;
   logic [15:0]       result;
   logic              byte_vld;
   logic              byte_even;
   logic              byte_last;
   logic              empty_fin;
   logic              done_q;

   cks_regs #(
      .ADDR_W (ADDR_W),
      .LEN_W  (LEN_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .we          (reg_we),
      .addr        (reg_addr),
      .wdata       (reg_wdata),
      .finish      (finish),
      .result_in   (result),
      .busy        (busy),
      .launch      (launch),
      .base        (base),
      .len         (len),
      .launch_seed (launch_seed),
      .rdata       (reg_rdata)
   );

   cks_fetch #(
      .ADDR_W    (ADDR_W),
      .LEN_W     (LEN_W),
      .BUF_BYTES (BUF_BYTES)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (launch),
      .base      (base),
      .len       (len),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .byte_vld  (byte_vld),
      .byte_even (byte_even),
      .byte_last (byte_last),
      .empty_fin (empty_fin)
   );

   cks_accum #(
      .MAP_ZERO (MAP_ZERO)
   ) u_accum (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (launch),
      .launch_seed (launch_seed),
      .byte_vld    (byte_vld),
      .byte_even   (byte_even),
      .byte_last   (byte_last),
      .byte_data   (mem_rd_data),
      .empty_fin   (empty_fin),
      .finish      (finish),
      .result      (result)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else begin
         done_q <= finish;
      end
   end

   assign done_o = done_q;
   assign irq_o  = done_q;

endmodule

// File: rtl/cks_dma_checker.sv
module cks_dma_checker #(
   parameter int unsigned ADDR_W    = 15,
   parameter int unsigned LEN_W     = 16,
   parameter int unsigned BUF_BYTES = 24576
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [2:0]        reg_addr,
   input logic              go_bit,
   input logic              copy_bit,
   input logic              mem_rd_en,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              done_o,
   input logic              busy,
   input logic [ADDR_W-1:0] base,
   input logic [LEN_W-1:0]  len
);

   localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BUF_BYTES - 1);

   // R2: completion pulse lasts one cycle
   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R2: completion pulse follows the end of a busy period
   p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy && $past(busy)));

   // R2: an accepted go request makes the engine busy
   p_go_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd0 && go_bit && !copy_bit && !busy) |=> busy);

   // R8: a copy request never starts the engine
   p_copy_rejected_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == 3'd0 && copy_bit && !busy) |=> !busy);

   // R11: no reads while idle
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_rd_en);

   // R7: consecutive reads step by one and wrap at the buffer end
   p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |->
         (mem_addr == (($past(mem_addr) == LAST_A) ? '0 : $past(mem_addr) + 1'b1)));

   // R9: window registers are frozen during an operation
   p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(base) && $stable(len)));

endmodule

bind cks_dma_engine cks_dma_checker #(
   .ADDR_W    (ADDR_W),
   .LEN_W     (LEN_W),
   .BUF_BYTES (BUF_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .go_bit    (reg_wdata[0]),
   .copy_bit  (reg_wdata[1]),
   .mem_rd_en (mem_rd_en),
   .mem_addr  (mem_addr),
   .done_o    (done_o),
   .busy      (busy),
   .base      (base),
   .len       (len)
);

// File: tb/tb_cks_dma_engine.sv
module tb_cks_dma_engine;

   localparam int AW  = 6;
   localparam int LW  = 8;
   localparam int BUF = 48;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [15:0]   reg_wdata = 16'd0;
   logic [15:0]   reg_rdata;
   logic          mem_rd_en;
   logic [AW-1:0] mem_addr;
   logic [7:0]    mem_rd_data = 8'd0;
   logic          done_o;
   logic          irq_o;

   logic [7:0] mem [0:63];

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   cks_dma_engine #(
      .ADDR_W    (AW),
      .LEN_W     (LW),
      .BUF_BYTES (BUF),
      .MAP_ZERO  (1)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .mem_rd_en   (mem_rd_en),
      .mem_addr    (mem_addr),
      .mem_rd_data (mem_rd_data),
      .done_o      (done_o),
      .irq_o       (irq_o)
   );

   // synchronous RAM with one cycle of read latency
   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem[mem_addr];
   end

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // behavioural timing model
   bit m_busy = 0;
   bit m_done = 0;
   int m_cnt = 0;
   int m_rd_rem = 0;
   int m_addr = 0;
   int m_base = 0;
   int m_len = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_busy <= 0; m_done <= 0; m_cnt <= 0;
         m_rd_rem <= 0; m_addr <= 0; m_base <= 0; m_len <= 0;
      end else begin
         m_done <= 0;
         if (m_rd_rem > 0) begin
            m_rd_rem <= m_rd_rem - 1;
            m_addr <= (m_addr == BUF - 1) ? 0 : m_addr + 1;
         end
         if (m_busy) begin
            if (m_cnt == 0) begin
               m_busy <= 0;
               m_done <= 1;
            end else begin
               m_cnt <= m_cnt - 1;
            end
         end else if (reg_we) begin
            if (reg_addr == 3'd1) m_base <= int'(reg_wdata[AW-1:0]);
            if (reg_addr == 3'd2) m_len <= int'(reg_wdata[LW-1:0]);
            if (reg_addr == 3'd0 && reg_wdata[0] && !reg_wdata[1]) begin
               m_busy <= 1;
               m_cnt <= m_len;
               m_rd_rem <= m_len;
               m_addr <= m_base;
            end
         end
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(mem_rd_en == (m_rd_rem > 0), "R11 read enable", 32'(mem_rd_en), 32'(m_rd_rem > 0));
         if (m_rd_rem > 0)
            check(int'(mem_addr) == m_addr, "R7 read address", 32'(mem_addr), 32'(m_addr));
         check(done_o == m_done, "R2 done pulse", 32'(done_o), 32'(m_done));
         check(irq_o == m_done, "R2 irq pulse", 32'(irq_o), 32'(m_done));
         if (reg_addr == 3'd0)
            check(reg_rdata[0] == m_busy, "R2 go bit", 32'(reg_rdata[0]), 32'(m_busy));
      end
   end

   function automatic logic [15:0] ref_sum(int base, int len, bit use_seed, logic [15:0] seed);
      int acc;
      int a;
      int w;
      int res;
      acc = use_seed ? int'(seed) : 0;
      a = base;
      w = 0;
      for (int i = 0; i < len; i++) begin
         if (i % 2 == 0) w = int'(mem[a]) << 8;
         else w = w + int'(mem[a]);
         a = (a == BUF - 1) ? 0 : a + 1;
         if (i % 2 == 1 || i == len - 1) begin
            acc = acc + w;
            if (acc > 32'hFFFF) acc = acc - 32'hFFFF;
         end
      end
      res = (~acc) & 32'hFFFF;
      if (res == 0) res = 32'hFFFF;
      return 16'(res);
   endfunction

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      reg_we = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      @(posedge clk);
      #2;
      reg_we = 1'b0;
      reg_addr = 3'd0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
      reg_addr = 3'd0;
   endtask

   task automatic wait_done(input string req);
      bit seen;
      seen = 0;
      for (int k = 0; k < 400; k++) begin
         if (done_o) begin
            seen = 1;
            break;
         end
         @(posedge clk);
         #2;
      end
      check(seen, req, 32'(seen), 32'd1);
      @(posedge clk);
      #2;
   endtask

   task automatic run_op(input int base, input int len, input bit use_seed,
                         input logic [15:0] seed, input string req);
      logic [15:0] v;
      wr(3'd1, 16'(base));
      wr(3'd2, 16'(len));
      wr(3'd3, seed);
      wr(3'd0, {13'd0, use_seed, 1'b0, 1'b1});
      wait_done({req, " completion"});
      rd(3'd4, v);
      check(v == ref_sum(base, len, use_seed, seed), req, 32'(v),
            32'(ref_sum(base, len, use_seed, seed)));
      rd(3'd0, v);
      check(v[0] == 1'b0, {req, " go cleared"}, 32'(v[0]), 32'd0);
   endtask

   initial begin
      #(8 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [15:0] keep;
      for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + 11) & 255);
      mem[40] = 8'hFF;
      mem[41] = 8'hFF;
      mem[20] = 8'hFF;
      mem[21] = 8'hFF;
      mem[22] = 8'hFF;
      mem[23] = 8'hFF;

      repeat (3) @(posedge clk);
      #2;
      rst_n = 1'b1;
      #1;

      // R1: reset state
      for (int r = 0; r < 5; r++) begin
         rd(3'(r), v);
         check(v == 16'h0000, "R1 register reset", 32'(v), 32'h0);
      end
      check(!done_o && !irq_o && !mem_rd_en, "R1 outputs idle",
            32'({done_o, irq_o, mem_rd_en}), 32'h0);
      @(posedge clk);
      #2;

      run_op(0, 4, 0, 16'h0000, "R3 R4 even length");
      run_op(5, 5, 0, 16'h0000, "R3 odd length pad");
      run_op(20, 6, 0, 16'h0000, "R4 end-around carry");
      run_op(8, 10, 1, 16'h1234, "R5 host seed");
      run_op(8, 10, 0, 16'hFFFF, "R5 seed ignored when not selected");
      run_op(0, 0, 1, 16'h1234, "R6 zero length with seed");
      rd(3'd4, v);
      check(v == 16'hEDCB, "R6 complement of seed", 32'(v), 32'hEDCB);
      run_op(3, 0, 0, 16'h5555, "R6 zero length default seed");
      run_op(44, 9, 0, 16'h0000, "R7 wrap at buffer end");
      run_op(40, 2, 0, 16'h0000, "R10 zero mapped to FFFF");
      rd(3'd4, v);
      check(v == 16'hFFFF, "R10 mapped value", 32'(v), 32'hFFFF);
      run_op(0, 0, 1, 16'hFFFF, "R10 zero-length all-ones seed");
      run_op(1, 47, 1, 16'hBEEF, "R4 long window");

      // R8: copy request is refused
      rd(3'd4, keep);
      wr(3'd0, 16'h0003);
      rd(3'd0, v);
      check(v[0] == 1'b0, "R8 go stays clear", 32'(v[0]), 32'd0);
      check(v[1] == 1'b1, "R8 copy bit stored", 32'(v[1]), 32'd1);
      repeat (4) begin
         @(posedge clk);
         #2;
         check(!mem_rd_en && !done_o, "R8 no activity", 32'({mem_rd_en, done_o}), 32'd0);
      end
      rd(3'd4, v);
      check(v == keep, "R8 result unchanged", 32'(v), 32'(keep));
      wr(3'd0, 16'h0000);

      // R9: writes while busy are ignored
      wr(3'd1, 16'd0);
      wr(3'd2, 16'd20);
      wr(3'd3, 16'h4321);
      wr(3'd0, 16'h0001);
      wr(3'd2, 16'd3);
      wr(3'd1, 16'd10);
      wr(3'd3, 16'hAAAA);
      wait_done("R9 completion");
      rd(3'd4, v);
      check(v == ref_sum(0, 20, 0, 16'h0), "R9 result from original window", 32'(v),
            32'(ref_sum(0, 20, 0, 16'h0)));
      rd(3'd2, v);
      check(v == 16'd20, "R9 length kept", 32'(v), 32'd20);
      rd(3'd1, v);
      check(v == 16'd0, "R9 start address kept", 32'(v), 32'd0);
      rd(3'd3, v);
      check(v == 16'h4321, "R9 seed kept", 32'(v), 32'h4321);

      repeat (3) @(posedge clk);
      #2;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule